// File: doc/BRIEF.md
# Input Change-Notification Interrupt Controller

This peripheral watches a group of digital input pins and raises one shared interrupt flag whenever an enabled pin holds a value different from the one captured at the last read of the port. Each pin passes through a synchronizer and then a stability filter. A change must persist for a configurable number of consecutive samples before the block accepts it, so short glitches are not guaranteed to be seen.

Software sets a per-pin enable mask, an interrupt enable and a 3-bit priority through a small register interface. The flag is the only change indication, and it is shared by all pins. Software finds the pin that moved by comparing the current port value with the value it read at the previous interrupt. Reading the port loads the accepted pin values into a reference latch. This removes the mismatch and arms detection of the next change. A clear of the flag written while the mismatch persists does not hold, so the usual service routine is to read the port first and then clear the flag.

Top module: `chg_notify_ctrl`

## Requirements
- R1: A pin change is accepted only after the synchronized value has differed from the accepted value for STABLE_CYCLES consecutive samples (default 3). A pulse lasting fewer samples never sets the flag.
- R2: A pin whose bit in the mask register (address 1, bit i = pin i) is 0 never contributes to setting the flag.
- R3: The flag (address 3, bit 0) is set when any enabled accepted pin differs from its reference bit. Once set, it remains set until it is cleared.
- R4: A read of address 0 returns the accepted pin values and loads them into the reference latch. After that read, a flag clear stays cleared.
- R5: Writing 1 to bit 0 of address 3 clears the flag on that edge. If the mismatch still exists, the flag sets again on the following edge.
- R6: `irq_o` is high exactly when the flag is set and the interrupt enable (address 2, bit 0) is 1.
- R7: The priority field (address 2, bits 3:1) is stored and driven on `irq_prio_o`. It changes only when address 2 is written.
- R8: After reset, the flag, the mask, the interrupt enable and the priority are all 0, and the reference latch holds the pin values that were present during reset. Enabling all pins afterwards does not set the flag.
- R9: If an accepted pin change lands on the same edge as a port read, the latch captures the earlier value. The change then sets the flag and is not lost.
- R10: Writing a mask that newly enables a pin which already differs from its reference bit sets the flag on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | N_PINS | Asynchronous pin inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe; a read of address 0 captures the reference |
| bus_addr_i | input | 2 | Register address: 0 port, 1 mask, 2 control, 3 flag |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address (combinational) |
| irq_o | output | 1 | Interrupt request |
| irq_prio_o | output | 3 | Stored interrupt priority |

## Verification
The hardest case to reach is R9. There, the accepted value of a pin must change on the same clock edge that carries a port read, and the filter decides that edge through its synchronizer and stability counter. The stimulus changes a pin just after a falling edge and waits out exactly the synchronizer and filter latency, four edges. It then raises the read strobe so that the fifth edge both accepts the change and captures the reference. The bench confirms that the read returned the old value and that the flag rises afterwards. The one-cycle dip of R5 is observed on `irq_o` half a cycle after the clearing edge, and again one edge later.

// File: rtl/cnp_pkg.sv
package cnp_pkg;
   localparam int PRIO_W = 3;

   typedef enum logic [1:0] {
      REG_PORT = 2'd0,
      REG_MASK = 2'd1,
      REG_CTRL = 2'd2,
      REG_FLAG = 2'd3
   } reg_sel_e;

   localparam int CTRL_IE_BIT   = 0;
   localparam int CTRL_PRIO_LSB = 1;
   localparam int FLAG_BIT      = 0;
endpackage

// File: rtl/cnp_sync.sv
module cnp_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cnp_filter.sv
module cnp_filter #(
   parameter int W      = 8,
   parameter int STABLE = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] acc_o
);
   generate
      if (STABLE <= 1) begin : g_pass
         assign acc_o = raw_i;
      end else begin : g_count
         localparam int CNT_W = $clog2(STABLE);
         for (genvar p = 0; p < W; p++) begin : g_pin
            logic [CNT_W-1:0] cnt_q;
            logic             acc_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  cnt_q <= '0;
                  acc_q <= 1'b0;
               end else if (raw_i[p] == acc_q) begin
                  cnt_q <= '0;
               end else if (cnt_q == CNT_W'(STABLE - 1)) begin
                  acc_q <= raw_i[p];
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            assign acc_o[p] = acc_q;
         end
      end
   endgenerate
endmodule

// File: rtl/cnp_detect.sv
module cnp_detect #(
   parameter int W        = 8,
   parameter int INIT_CYC = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] mask_i,
   input  logic         capture_i,
   output logic [W-1:0] ref_o,
   output logic         mismatch_o
);
   localparam int INIT_W = $clog2(INIT_CYC + 1);

   logic [INIT_W-1:0] init_q;
   logic              primed;
   logic [W-1:0]      ref_q;

   assign primed = (init_q == INIT_W'(INIT_CYC));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         init_q <= '0;
      end else if (!primed) begin
         init_q <= init_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q <= '0;
      end else if (!primed || capture_i) begin
         ref_q <= acc_i;
      end
   end

   assign ref_o      = ref_q;
   assign mismatch_o = |((acc_i ^ ref_q) & mask_i);
endmodule

// File: rtl/chg_notify_ctrl.sv
module chg_notify_ctrl
   import cnp_pkg::*;
#(
   parameter int N_PINS        = 8,
   parameter int DATA_W        = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int STABLE_CYCLES = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_PINS-1:0] pins_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic [PRIO_W-1:0] irq_prio_o
);
   localparam int INIT_CYC = SYNC_STAGES + STABLE_CYCLES + 1;

   initial begin
      assert (N_PINS >= 1 && N_PINS <= DATA_W)
         else $fatal(1, "N_PINS must lie in 1..DATA_W");
      assert (DATA_W >= CTRL_PRIO_LSB + PRIO_W)
         else $fatal(1, "DATA_W too narrow for control field");
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "SYNC_STAGES must be at least 2");
      assert (STABLE_CYCLES >= 1)
         else $fatal(1, "STABLE_CYCLES must be at least 1");
   end

   reg_sel_e          sel;
   logic [N_PINS-1:0] sync_q;
   logic [N_PINS-1:0] filt_q;
   logic [N_PINS-1:0] ref_q;
   logic [N_PINS-1:0] mask_q;
   logic              ie_q;
   logic [PRIO_W-1:0] prio_q;
   logic              flag_q;
   logic              mismatch;
   logic              port_rd;
   logic              flag_clr;

   assign sel      = reg_sel_e'(bus_addr_i);
   assign port_rd  = bus_rd_i && (sel == REG_PORT);
   assign flag_clr = bus_wr_i && (sel == REG_FLAG) && bus_wdata_i[FLAG_BIT];

   cnp_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins_i),
      .q_o   (sync_q)
   );

   cnp_filter #(.W(N_PINS), .STABLE(STABLE_CYCLES)) filt_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (sync_q),
      .acc_o (filt_q)
   );

   cnp_detect #(.W(N_PINS), .INIT_CYC(INIT_CYC)) det_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acc_i     (filt_q),
      .mask_i    (mask_q),
      .capture_i (port_rd),
      .ref_o     (ref_q),
      .mismatch_o(mismatch)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
         ie_q   <= 1'b0;
         prio_q <= '0;
      end else if (bus_wr_i) begin
         if (sel == REG_MASK) begin
            mask_q <= bus_wdata_i[N_PINS-1:0];
         end
         if (sel == REG_CTRL) begin
            ie_q   <= bus_wdata_i[CTRL_IE_BIT];
            prio_q <= bus_wdata_i[CTRL_PRIO_LSB +: PRIO_W];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end else if (mismatch) begin
         flag_q <= 1'b1;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      unique case (sel)
         REG_PORT: bus_rdata_o[N_PINS-1:0] = filt_q;
         REG_MASK: bus_rdata_o[N_PINS-1:0] = mask_q;
         REG_CTRL: begin
            bus_rdata_o[CTRL_IE_BIT]                = ie_q;
            bus_rdata_o[CTRL_PRIO_LSB +: PRIO_W]    = prio_q;
         end
         REG_FLAG: bus_rdata_o[FLAG_BIT] = flag_q;
         default:  bus_rdata_o = '0;
      endcase
   end

   assign irq_o      = flag_q & ie_q;
   assign irq_prio_o = prio_q;
endmodule

// File: rtl/cnp_checker.sv
module cnp_checker #(
   parameter int N_PINS = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              port_rd,
   input logic              flag_clr,
   input logic              ctrl_wr,
   input logic [N_PINS-1:0] filt_q,
   input logic [N_PINS-1:0] ref_q,
   input logic              mismatch,
   input logic              flag_q,
   input logic [2:0]        prio_q
);
   // R5
   clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_clr |=> !flag_q);

   // R3
   flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mismatch && !flag_clr) |=> flag_q);

   // R3
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !flag_clr) |=> flag_q);

   // R4
   ref_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_rd |=> (ref_q == $past(filt_q)));

   // R7
   prio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_wr |=> $stable(prio_q));
endmodule

bind chg_notify_ctrl cnp_checker #(.N_PINS(N_PINS)) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .port_rd (port_rd),
   .flag_clr(flag_clr),
   .ctrl_wr (bus_wr_i && (sel == cnp_pkg::REG_CTRL)),
   .filt_q  (filt_q),
   .ref_q   (ref_q),
   .mismatch(mismatch),
   .flag_q  (flag_q),
   .prio_q  (prio_q)
);

// File: tb/chg_notify_ctrl_tb.sv
module chg_notify_ctrl_tb_top;
   localparam int NP = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pins = 8'hA5;
   logic          wr = 1'b0;
   logic          rd = 1'b0;
   logic [1:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic [2:0]    prio;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   logic [DW-1:0] rv;

   always #10 clk = ~clk;

   chg_notify_ctrl #(.N_PINS(NP), .DATA_W(DW)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pins_i     (pins),
      .bus_wr_i   (wr),
      .bus_rd_i   (rd),
      .bus_addr_i (addr),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .irq_o      (irq),
      .irq_prio_o (prio)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd = 1'b1; addr = a;
      #5 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic settle();
      repeat (10) @(negedge clk);
   endtask

   task automatic service();
      bus_read(2'd0, rv);
      bus_write(2'd3, 16'h1);
      settle();
   endtask

   task automatic t_reset();
      check("R8 irq", {15'd0, irq}, 16'd0);
      check("R8 prio", {13'd0, prio}, 16'd0);
      bus_read(2'd1, rv); check("R8 mask", rv, 16'd0);
      bus_read(2'd2, rv); check("R8 ctrl", rv, 16'd0);
      bus_read(2'd3, rv); check("R8 flag", rv, 16'd0);
      bus_write(2'd1, 16'h00FF);
      settle();
      bus_read(2'd3, rv); check("R8 no flag after enable", rv, 16'd0);
   endtask

   task automatic t_basic();
      bus_write(2'd2, 16'h000B);
      check("R7 prio", {13'd0, prio}, 16'd5);
      pins[0] = ~pins[0];
      settle();
      bus_read(2'd3, rv); check("R3 flag set", rv, 16'd1);
      check("R6 irq on", {15'd0, irq}, 16'd1);
      bus_read(2'd0, rv); check("R4 port value", rv, {8'd0, pins});
      bus_write(2'd3, 16'h1);
      settle();
      bus_read(2'd3, rv); check("R4 clear holds", rv, 16'd0);
   endtask

   task automatic t_clear_no_read();
      pins[1] = ~pins[1];
      settle();
      bus_write(2'd3, 16'h1);
      check("R5 dip", {15'd0, irq}, 16'd0);
      @(negedge clk);
      check("R5 reassert", {15'd0, irq}, 16'd1);
      service();
      bus_read(2'd3, rv); check("R5 cleared after read", rv, 16'd0);
   endtask

   task automatic t_irq_gate();
      bus_write(2'd2, 16'h000A);
      pins[3] = ~pins[3];
      settle();
      check("R6 irq gated", {15'd0, irq}, 16'd0);
      bus_read(2'd3, rv); check("R6 flag still set", rv, 16'd1);
      bus_write(2'd2, 16'h000B);
      check("R6 irq after enable", {15'd0, irq}, 16'd1);
      check("R7 prio kept", {13'd0, prio}, 16'd5);
      service();
   endtask

   task automatic t_mask();
      bus_write(2'd1, 16'h000F);
      pins[7] = ~pins[7];
      settle();
      bus_read(2'd3, rv); check("R2 masked pin", rv, 16'd0);
      check("R2 irq low", {15'd0, irq}, 16'd0);
      bus_write(2'd1, 16'h008F);
      check("R10 not yet", {15'd0, irq}, 16'd0);
      @(negedge clk);
      check("R10 flag next edge", {15'd0, irq}, 16'd1);
      service();
      bus_write(2'd1, 16'h00FF);
   endtask

   task automatic t_pulse();
      pins[2] = ~pins[2];
      repeat (2) @(negedge clk);
      pins[2] = ~pins[2];
      settle();
      bus_read(2'd3, rv); check("R1 short pulse ignored", rv, 16'd0);
      pins[2] = ~pins[2];
      repeat (4) @(negedge clk);
      pins[2] = ~pins[2];
      settle();
      bus_read(2'd3, rv); check("R1 long pulse seen", rv, 16'd1);
      service();
      bus_read(2'd3, rv); check("R1 cleared", rv, 16'd0);
   endtask

   task automatic t_race();
      logic [NP-1:0] old_pins;
      old_pins = pins;
      pins[4] = ~pins[4];
      repeat (4) @(negedge clk);
      rd = 1'b1; addr = 2'd0;
      #5 rv = rdata;
      @(negedge clk);
      rd = 1'b0;
      check("R9 read gave old value", rv, {8'd0, old_pins});
      settle();
      bus_read(2'd3, rv); check("R9 change not lost", rv, 16'd1);
      service();
      bus_read(2'd3, rv); check("R9 cleared", rv, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_basic();
      t_clear_no_read();
      t_irq_gate();
      t_mask();
      t_pulse();
      t_race();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule